// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block is the instruction front end of a small processor whose code and data share one byte-wide memory. It reads that memory through a request/acknowledge port with a 16-bit address. After reset it takes its start address from the two topmost bytes of the address space. It then reads an opcode of one or two bytes. A length decoder works out from the opcode how many operand bytes follow. The sequencer reads those bytes from the consecutive addresses and hands the finished instruction to the execute stage over a valid/accept handshake.

Nothing in memory marks a byte as code. The decoded length alone decides where the next opcode begins. The program counter keeps the address of the current instruction while that instruction waits on the output. It moves on when the execute stage accepts the instruction. At that point it goes either past the instruction or to a redirect target. The target is an absolute address, or a signed 8-bit offset added to the address that follows the instruction.

Top module: `vlen_fetch_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, mem_req is 1, mem_addr is 0xFFFE and instr_valid is 0.
- R2: The start address is read high byte first from 0xFFFE and then low byte from 0xFFFF. The first opcode read uses that address, which is reported as instr_pc.
- R3: mem_addr stays unchanged from the cycle a read is requested until the cycle mem_ack is seen.
- R4: Without a prefix, the operand count is set by opcode bits [7:6]: 00 gives 0, 01 gives 1, 10 gives 2 and 11 gives 1. instr_prefix then reads 0x00.
- R5: A first byte of 0x10 or 0x11 is a prefix. It is reported on instr_prefix, and the next byte becomes instr_opcode. After 0x10 the count is 2 when bit 7 of the second byte is set and 0 when it is clear. After 0x11 the count is always 1.
- R6: Operand bytes are read from the addresses right after the opcode and collected high byte first. A single operand byte appears in instr_operand[7:0] with the upper byte zero. With no operand, instr_operand is zero.
- R7: While instr_valid is 1 and instr_accept is 0, the instruction fields stay stable and mem_req stays 0.
- R8: When an instruction is accepted without a redirect, the next opcode is read at instr_pc plus the instruction length (prefix, opcode and operand bytes).
- R9: When an instruction is accepted with redir_valid=1 and redir_rel=0, the next opcode is read at redir_target.
- R10: When an instruction is accepted with redir_valid=1 and redir_rel=1, the next opcode is read at instr_pc plus the length plus the sign-extended redir_target[7:0].
- R11: redir_valid has no effect in a cycle where the instruction is not accepted.
- R12: A redirect into the middle of an instruction decodes the operand byte found there as an opcode. No realignment takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Read address |
| mem_ack | input | 1 | Read done; mem_rdata valid this cycle |
| mem_rdata | input | 8 | Read data |
| instr_valid | output | 1 | Assembled instruction available |
| instr_accept | input | 1 | Execute stage takes the instruction |
| instr_pc | output | 16 | Address of the instruction's first byte |
| instr_prefix | output | 8 | Prefix byte, or 0x00 if none |
| instr_opcode | output | 8 | Final opcode byte |
| instr_opcnt | output | 2 | Operand byte count |
| instr_operand | output | 16 | Operand, high byte first |
| redir_valid | input | 1 | Redirect with this acceptance |
| redir_rel | input | 1 | 1 = relative offset, 0 = absolute target |
| redir_target | input | 16 | Absolute target, or offset in bits [7:0] |

## Verification
Acceptance of an instruction and a redirect request can happen in the same cycle. The redirect must then take the place of the sequential step. The bench sets instr_accept and redir_valid on the same clock edge, once with a backward relative offset and once with absolute targets. One of these absolute targets points into an operand byte. The bench checks the redirect by the address and fields of the next instruction presented. It also holds redir_valid high through cycles without acceptance. It then shows that the sequential successor follows.

// File: rtl/vlf_pkg.sv
// Package: shared state encoding and byte constants for the fetch sequencer.
// Assumes byte-wide memory and prefixes fixed at build time.
package vlf_pkg;

    typedef enum logic [2:0] {
        ST_VEC_HI = 3'd0,
        ST_VEC_LO = 3'd1,
        ST_OPC    = 3'd2,
        ST_OPC2   = 3'd3,
        ST_OPND   = 3'd4,
        ST_EXEC   = 3'd5
    } fetch_state_e;

    localparam logic [7:0] PFX_WIDE  = 8'h10;
    localparam logic [7:0] PFX_SHORT = 8'h11;
    localparam logic [7:0] PFX_NONE  = 8'h00;

endpackage

// File: rtl/vlf_len_decode.sv
// Module: operand length decoder.
// Works out from the final opcode byte and its prefix how many operand bytes
// follow (0..2), and flags a raw byte that is itself a prefix.
// Assumes the prefix input is PFX_NONE when no prefix was read.
module vlf_len_decode
    import vlf_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] prefix,
    input  logic [BYTE_W-1:0] opcode,
    output logic [1:0]        opcnt,
    output logic              is_prefix
);

    // Count lookup: computed per prefix group instead of stored tables.
    always_comb begin
        if (prefix == PFX_WIDE) begin
            opcnt = opcode[BYTE_W-1] ? 2'd2 : 2'd0;
        end else if (prefix == PFX_SHORT) begin
            opcnt = 2'd1;
        end else begin
            case (opcode[BYTE_W-1 -: 2])
                2'b00:   opcnt = 2'd0;
                2'b01:   opcnt = 2'd1;
                2'b10:   opcnt = 2'd2;
                default: opcnt = 2'd1;
            endcase
        end
    end

    // Prefix recognition on a first opcode byte.
    assign is_prefix = (opcode == PFX_WIDE) || (opcode == PFX_SHORT);

    // Range guard on the count.
    always_comb begin
        AST_CNT_RANGE: assert (opcnt != 2'd3); // R4
    end

endmodule

// File: rtl/vlf_pc_unit.sv
// Module: program counter.
// Loads the start address one byte at a time (high, then low), then holds the
// address of the current instruction. It moves on only when the execute stage
// accepts that instruction: by the instruction length, to an absolute target,
// or by a signed byte offset counted from the end of the instruction.
module vlf_pc_unit #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_hi_we,
    input  logic              vec_lo_we,
    input  logic [7:0]        vec_byte,
    input  logic              step_en,
    input  logic [LEN_W-1:0]  step_len,
    input  logic              jump_en,
    input  logic              jump_rel,
    input  logic [ADDR_W-1:0] jump_arg,
    output logic [ADDR_W-1:0] pc
);

    localparam int HI_W = ADDR_W - 8;

    logic [ADDR_W-1:0] seq_next;
    logic [ADDR_W-1:0] rel_next;
    logic [ADDR_W-1:0] off_ext;

    // Address after the current instruction, and the relative target.
    always_comb begin
        seq_next = pc + ADDR_W'(step_len);
        off_ext  = {{HI_W{jump_arg[7]}}, jump_arg[7:0]};
        rel_next = seq_next + off_ext;
    end

    // PC register: vector load, then redirect over sequential step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (vec_hi_we) begin
            pc <= {vec_byte, pc[7:0]};
        end else if (vec_lo_we) begin
            pc <= {pc[ADDR_W-1:8], vec_byte};
        end else if (step_en && jump_en) begin
            pc <= jump_rel ? rel_next : jump_arg;
        end else if (step_en) begin
            pc <= seq_next;
        end
    end

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !jump_en && !vec_hi_we && !vec_lo_we)
        |=> pc == $past(pc) + ADDR_W'($past(step_len))); // R8

endmodule

// File: rtl/vlf_operand_asm.sv
// Module: operand collector.
// Shifts each incoming operand byte in from the low end, so the first byte
// read ends up most significant. Cleared when a new opcode arrives.
module vlf_operand_asm #(
    parameter int OPND_BYTES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  shift_en,
    input  logic [7:0]            byte_in,
    output logic [OPND_BYTES*8-1:0] operand
);

    localparam int OW = OPND_BYTES * 8;

    // Operand shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            operand <= '0;
        end else if (shift_en) begin
            operand <= {operand[OW-9:0], byte_in};
        end
    end

endmodule

// File: rtl/vlen_fetch_seq.sv
// Module: variable-length instruction fetch sequencer (top).
// Reads the start vector, then fetches an opcode of one or two bytes and its
// decoded number of operand bytes from consecutive addresses, and holds the
// result for the execute stage until it is accepted. Assumes mem_ack is
// asserted for one cycle per read, with mem_rdata valid in that cycle.
module vlen_fetch_seq
    import vlf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic              instr_valid,
    input  logic              instr_accept,
    output logic [ADDR_W-1:0] instr_pc,
    output logic [7:0]        instr_prefix,
    output logic [7:0]        instr_opcode,
    output logic [1:0]        instr_opcnt,
    output logic [15:0]       instr_operand,
    input  logic              redir_valid,
    input  logic              redir_rel,
    input  logic [ADDR_W-1:0] redir_target
);

    localparam int LEN_W = 3;
    localparam logic [ADDR_W-1:0] VEC_HI_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] VEC_LO_ADDR = {ADDR_W{1'b1}};

    fetch_state_e      state;
    logic [LEN_W-1:0]  idx;
    logic [1:0]        remain;
    logic [7:0]        prefix_q;
    logic [7:0]        opcode_q;
    logic [1:0]        opcnt_q;
    logic [ADDR_W-1:0] pc;
    logic [7:0]        dec_pfx;
    logic [1:0]        dec_cnt;
    logic              dec_is_pfx;
    logic              take;
    logic              got;

    assign got  = mem_req && mem_ack;
    assign take = (state == ST_EXEC) && instr_accept;

    // Decoder prefix input: only the second opcode byte sees a prefix.
    assign dec_pfx = (state == ST_OPC2) ? prefix_q : PFX_NONE;

    vlf_len_decode u_dec (
        .prefix    (dec_pfx),
        .opcode    (mem_rdata),
        .opcnt     (dec_cnt),
        .is_prefix (dec_is_pfx)
    );

    vlf_pc_unit #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .vec_hi_we (got && state == ST_VEC_HI),
        .vec_lo_we (got && state == ST_VEC_LO),
        .vec_byte  (mem_rdata),
        .step_en   (take),
        .step_len  (idx),
        .jump_en   (redir_valid),
        .jump_rel  (redir_rel),
        .jump_arg  (redir_target),
        .pc        (pc)
    );

    vlf_operand_asm #(.OPND_BYTES(2)) u_opnd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (got && state == ST_OPC),
        .shift_en (got && state == ST_OPND),
        .byte_in  (mem_rdata),
        .operand  (instr_operand)
    );

    // Memory request and address: vector slots, then pc plus byte index.
    always_comb begin
        mem_req = (state != ST_EXEC);
        case (state)
            ST_VEC_HI: mem_addr = VEC_HI_ADDR;
            ST_VEC_LO: mem_addr = VEC_LO_ADDR;
            default:   mem_addr = pc + ADDR_W'(idx);
        endcase
    end

    // Sequencer state, byte index and decoded instruction fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_VEC_HI;
            idx      <= '0;
            remain   <= '0;
            prefix_q <= PFX_NONE;
            opcode_q <= '0;
            opcnt_q  <= '0;
        end else begin
            case (state)
                ST_VEC_HI: if (got) state <= ST_VEC_LO;
                ST_VEC_LO: if (got) begin
                    state <= ST_OPC;
                    idx   <= '0;
                end
                ST_OPC: if (got) begin
                    idx <= LEN_W'(1);
                    if (dec_is_pfx) begin
                        prefix_q <= mem_rdata;
                        state    <= ST_OPC2;
                    end else begin
                        prefix_q <= PFX_NONE;
                        opcode_q <= mem_rdata;
                        opcnt_q  <= dec_cnt;
                        remain   <= dec_cnt;
                        state    <= (dec_cnt == 2'd0) ? ST_EXEC : ST_OPND;
                    end
                end
                ST_OPC2: if (got) begin
                    idx      <= LEN_W'(2);
                    opcode_q <= mem_rdata;
                    opcnt_q  <= dec_cnt;
                    remain   <= dec_cnt;
                    state    <= (dec_cnt == 2'd0) ? ST_EXEC : ST_OPND;
                end
                ST_OPND: if (got) begin
                    idx    <= idx + LEN_W'(1);
                    remain <= remain - 2'd1;
                    if (remain == 2'd1) state <= ST_EXEC;
                end
                ST_EXEC: if (instr_accept) begin
                    idx   <= '0;
                    state <= ST_OPC;
                end
                default: state <= ST_VEC_HI;
            endcase
        end
    end

    // Output view of the held instruction.
    always_comb begin
        instr_valid  = (state == ST_EXEC);
        instr_pc     = pc;
        instr_prefix = prefix_q;
        instr_opcode = opcode_q;
        instr_opcnt  = opcnt_q;
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_addr == $past(mem_addr)); // R3
    AST_NO_FETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |-> !mem_req); // R7
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !instr_accept) |=> instr_valid && $stable(instr_pc)
        && $stable(instr_opcode) && $stable(instr_operand) && $stable(instr_prefix)); // R7
    AST_VEC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_addr == VEC_HI_ADDR) |=> mem_addr == VEC_LO_ADDR); // R2

endmodule

// File: tb/vlen_fetch_seq_tb_top.sv
// Directed bench for the fetch sequencer: a latency-varying byte memory and
// one task per scenario, each checking the instruction it expects.
module vlen_fetch_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic        instr_valid;
    logic        instr_accept = 1'b0;
    logic [15:0] instr_pc;
    logic [7:0]  instr_prefix;
    logic [7:0]  instr_opcode;
    logic [1:0]  instr_opcnt;
    logic [15:0] instr_operand;
    logic        redir_valid = 1'b0;
    logic        redir_rel = 1'b0;
    logic [15:0] redir_target = 16'h0000;

    int checks = 0;
    int errors = 0;
    logic [7:0]  code [0:255];
    logic [15:0] ack_log [0:1];
    int          ack_n = 0;
    int          wait_cnt = 0;

    always #10 clk = ~clk;

    vlen_fetch_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .instr_valid(instr_valid), .instr_accept(instr_accept), .instr_pc(instr_pc),
        .instr_prefix(instr_prefix), .instr_opcode(instr_opcode), .instr_opcnt(instr_opcnt),
        .instr_operand(instr_operand), .redir_valid(redir_valid), .redir_rel(redir_rel),
        .redir_target(redir_target)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        if (a == 16'hFFFE) return 8'h00;
        if (a == 16'hFFFF) return 8'h40;
        if (a[15:8] == 8'h00) return code[a[7:0]];
        return 8'hEE;
    endfunction

    // Memory model: acknowledges after 0..3 idle cycles, set by address bits.
    always @(posedge clk) begin
        if (!rst_n || mem_ack || !mem_req) begin
            mem_ack  <= 1'b0;
            wait_cnt <= 0;
        end else if (wait_cnt >= int'(mem_addr[1:0])) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem_byte(mem_addr);
            wait_cnt  <= 0;
            if (ack_n < 2) ack_log[ack_n] <= mem_addr;
            ack_n <= ack_n + 1;
        end else begin
            wait_cnt <= wait_cnt + 1;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Waits for an instruction, checks it, optionally holds it, then accepts.
    task automatic expect_instr(input string req, input logic [15:0] pc,
                                input logic [7:0] pfx, input logic [7:0] op,
                                input logic [1:0] cnt, input logic [15:0] opnd,
                                input int hold, input logic ghost_redir,
                                input logic rdv, input logic rel, input logic [15:0] tgt);
        while (instr_valid !== 1'b1) @(negedge clk);
        check(req, "instr_pc", instr_pc, pc);
        check(req, "instr_prefix", {8'h00, instr_prefix}, {8'h00, pfx});
        check(req, "instr_opcode", {8'h00, instr_opcode}, {8'h00, op});
        check(req, "instr_opcnt", {14'h0, instr_opcnt}, {14'h0, cnt});
        check(req, "instr_operand", instr_operand, opnd);
        for (int i = 0; i < hold; i++) begin
            redir_valid  = ghost_redir;
            redir_rel    = 1'b0;
            redir_target = 16'h0000;
            @(negedge clk);
            check("R7", "valid held", {15'h0, instr_valid}, 16'h1);
            check("R7", "no fetch while held", {15'h0, mem_req}, 16'h0);
            check("R7", "pc held", instr_pc, pc);
            check("R7", "operand held", instr_operand, opnd);
        end
        instr_accept = 1'b1;
        redir_valid  = rdv;
        redir_rel    = rel;
        redir_target = tgt;
        @(negedge clk);
        instr_accept = 1'b0;
        redir_valid  = 1'b0;
        redir_rel    = 1'b0;
        redir_target = 16'h0000;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "mem_req in reset", {15'h0, mem_req}, 16'h1);
        check("R1", "mem_addr in reset", mem_addr, 16'hFFFE);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "instr_valid after reset", {15'h0, instr_valid}, 16'h0);
        check("R1", "vector addr after reset", mem_addr, 16'hFFFE);
    endtask

    task automatic t_vector;
        expect_instr("R2", 16'h0040, 8'h00, 8'h05, 2'd0, 16'h0000, 3, 1'b1, 1'b0, 1'b0, 16'h0);
        check("R2", "first vector read", ack_log[0], 16'hFFFE);
        check("R2", "second vector read", ack_log[1], 16'hFFFF);
    endtask

    task automatic t_plain_lengths;
        // R11: ghost redirect during hold above; sequential successor follows.
        expect_instr("R11", 16'h0041, 8'h00, 8'h45, 2'd1, 16'h00AB, 0, 1'b0, 1'b0, 1'b0, 16'h0);
        expect_instr("R6", 16'h0043, 8'h00, 8'h85, 2'd2, 16'h1234, 2, 1'b0, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic t_prefixed;
        expect_instr("R5", 16'h0046, 8'h10, 8'h90, 2'd2, 16'hBEEF, 0, 1'b0, 1'b0, 1'b0, 16'h0);
        expect_instr("R5", 16'h004A, 8'h11, 8'h22, 2'd1, 16'h0077, 0, 1'b0, 1'b0, 1'b0, 16'h0);
        expect_instr("R8", 16'h004D, 8'h10, 8'h05, 2'd0, 16'h0000, 0, 1'b0, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic t_redirects;
        // Branch at 0x4F, length 2, offset 0xFC: 0x51 - 4 = 0x4D.
        expect_instr("R4", 16'h004F, 8'h00, 8'hC0, 2'd1, 16'h00FC, 0, 1'b0, 1'b1, 1'b1, 16'h00FC);
        expect_instr("R10", 16'h004D, 8'h10, 8'h05, 2'd0, 16'h0000, 0, 1'b0, 1'b1, 1'b0, 16'h0060);
        expect_instr("R9", 16'h0060, 8'h00, 8'h41, 2'd1, 16'h0003, 0, 1'b0, 1'b1, 1'b0, 16'h0042);
    endtask

    task automatic t_desync;
        // Jump into operand byte 0xAB: decoded as opcode with two operands.
        expect_instr("R12", 16'h0042, 8'h00, 8'hAB, 2'd2, 16'h8512, 0, 1'b0, 1'b0, 1'b0, 16'h0);
        expect_instr("R12", 16'h0045, 8'h00, 8'h34, 2'd0, 16'h0000, 0, 1'b0, 1'b0, 1'b0, 16'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) code[i] = 8'h00;
        code[8'h40] = 8'h05;
        code[8'h41] = 8'h45; code[8'h42] = 8'hAB;
        code[8'h43] = 8'h85; code[8'h44] = 8'h12; code[8'h45] = 8'h34;
        code[8'h46] = 8'h10; code[8'h47] = 8'h90; code[8'h48] = 8'hBE; code[8'h49] = 8'hEF;
        code[8'h4A] = 8'h11; code[8'h4B] = 8'h22; code[8'h4C] = 8'h77;
        code[8'h4D] = 8'h10; code[8'h4E] = 8'h05;
        code[8'h4F] = 8'hC0; code[8'h50] = 8'hFC;
        code[8'h60] = 8'h41; code[8'h61] = 8'h03;
        @(negedge clk);
        t_reset();
        t_vector();
        t_plain_lengths();
        t_prefixed();
        t_redirects();
        t_desync();
        summary();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

endmodule